// File: doc/BRIEF.md
# Operand Detector and Unsigned Comparator

This combinational unit looks at two unsigned operands of a parameterised width and raises five flags. Two flags describe the first operand alone: every bit clear, or every bit set. Three flags relate the operands: the operands are equal, the first is strictly below the second, or the first is at or above the second.

The zero, all-ones and equality flags all come from one reusable all-ones detector, a balanced AND tree. The all-zeros case feeds that tree the inverted operand. The equality case feeds it the bitwise XNOR of the two operands. The ordering comes from a carry chain that forms the carry out of B plus the inverse of A plus one. For unsigned values that carry is set exactly when B is at least A. Combining the carry with the equality flag then gives a strict less-than.

Top module: `cmp_flag_unit`

## Requirements
- R1: `flag_ones` is 1 exactly when every bit of `opd_a` is 1.
- R2: `flag_zero` is 1 exactly when every bit of `opd_a` is 0.
- R3: `flag_eq` is 1 exactly when `opd_a` and `opd_b` match in every bit position.
- R4: `flag_lt` is 1 exactly when `opd_a` is strictly smaller than `opd_b` as an unsigned number.
- R5: `flag_ge` is always the inverse of `flag_lt`. It is 1 when `opd_a` is greater than or equal to `opd_b`.
- R6: Ordering is unsigned. An operand whose most significant bit is 1 compares greater than any operand whose most significant bit is 0, for example 0x8000 against 0x7FFF at width 16.
- R7: The internal carry out of `opd_b + ~opd_a + 1` is 1 exactly when `opd_b` is greater than or equal to `opd_a`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_a | input | WIDTH | First unsigned operand |
| opd_b | input | WIDTH | Second unsigned operand |
| flag_zero | output | 1 | opd_a has no bit set |
| flag_ones | output | 1 | opd_a has every bit set |
| flag_eq | output | 1 | opd_a equals opd_b |
| flag_lt | output | 1 | opd_a below opd_b, unsigned |
| flag_ge | output | 1 | opd_a at or above opd_b, unsigned |

## Verification
The bench builds two copies of the unit, one with WIDTH set to 4 and one with WIDTH set to 16. At width 4, all 256 operand pairs can be applied, so every carry-chain and tree case is covered exhaustively. At width 16, directed extremes around zero, all-ones and the sign-bit boundary are applied, followed by random pairs. Random pairs almost never match, so a share of them reuse one operand to keep the equality and borrow-free paths in play.

// File: rtl/cmp_flag_pkg.sv
package cmp_flag_pkg;

  // Carry out of a single full-adder position.
  function automatic logic fa_carry(input logic x, input logic y, input logic cin);
    return (x & y) | (x & cin) | (y & cin);
  endfunction

  // Smallest power of two that holds n leaves (n >= 1).
  function automatic int unsigned leaf_count(input int unsigned n);
    int unsigned p;
    p = 1;
    while (p < n) p = p * 2;
    return p;
  endfunction

endpackage

// File: rtl/cmp_ones_tree.sv
module cmp_ones_tree
  import cmp_flag_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] bits_in,
  output logic             all_set
);
  localparam int unsigned LEAVES = leaf_count(WIDTH);
  localparam int unsigned NODES  = 2 * LEAVES - 1;

  // Heap-ordered tree: node k has children 2k and 2k+1, leaves at LEAVES..NODES.
  logic [NODES:1] node;

  genvar g;
  generate
    for (g = 0; g < LEAVES; g++) begin : g_leaf
      if (g < WIDTH) begin : g_real
        assign node[LEAVES + g] = bits_in[g];
      end else begin : g_pad
        assign node[LEAVES + g] = 1'b1;
      end
    end
    for (g = 1; g < LEAVES; g++) begin : g_and
      assign node[g] = node[2*g] & node[2*g+1];
    end
  endgenerate

  assign all_set = node[1];
endmodule

// File: rtl/cmp_borrow_chain.sv
module cmp_borrow_chain
  import cmp_flag_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] minuend,
  input  logic [WIDTH-1:0] subtrahend,
  output logic             carry_out
);
  // Carry chain of minuend + ~subtrahend + 1; only the final carry is kept.
  logic [WIDTH:0] cy;

  assign cy[0] = 1'b1;

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_bit
      assign cy[g+1] = fa_carry(minuend[g], ~subtrahend[g], cy[g]);
    end
  endgenerate

  assign carry_out = cy[WIDTH];
endmodule

// File: rtl/cmp_flag_unit.sv
module cmp_flag_unit #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] opd_a,
  input  logic [WIDTH-1:0] opd_b,
  output logic             flag_zero,
  output logic             flag_ones,
  output logic             flag_eq,
  output logic             flag_lt,
  output logic             flag_ge
);
  logic [WIDTH-1:0] a_inv;
  logic [WIDTH-1:0] bit_match;
  logic             sub_carry;   // named for the checker: B + ~A + 1 carry

  assign a_inv     = ~opd_a;
  assign bit_match = ~(opd_a ^ opd_b);

  cmp_ones_tree #(.WIDTH(WIDTH)) u_ones_det (
    .bits_in (opd_a),
    .all_set (flag_ones)
  );

  cmp_ones_tree #(.WIDTH(WIDTH)) u_zero_det (
    .bits_in (a_inv),
    .all_set (flag_zero)
  );

  cmp_ones_tree #(.WIDTH(WIDTH)) u_eq_det (
    .bits_in (bit_match),
    .all_set (flag_eq)
  );

  cmp_borrow_chain #(.WIDTH(WIDTH)) u_chain (
    .minuend    (opd_b),
    .subtrahend (opd_a),
    .carry_out  (sub_carry)
  );

  assign flag_lt = sub_carry & ~flag_eq;
  assign flag_ge = ~flag_lt;
endmodule

// File: rtl/cmp_flag_unit_chk.sv
module cmp_flag_unit_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic [WIDTH-1:0] opd_a,
  input logic [WIDTH-1:0] opd_b,
  input logic             flag_zero,
  input logic             flag_ones,
  input logic             flag_eq,
  input logic             flag_lt,
  input logic             flag_ge,
  input logic             sub_carry
);
  always_comb begin
    if (!$isunknown({opd_a, opd_b})) begin
      AST_ONES_FLAG: assert (flag_ones == (&opd_a));                       // R1
      AST_ZERO_FLAG: assert (flag_zero == (opd_a == '0));                  // R2
      AST_NOT_BOTH_EXTREMES: assert (!(flag_zero && flag_ones));           // R2
      AST_EQ_FLAG: assert (flag_eq == (opd_a == opd_b));                   // R3
      AST_LT_FLAG: assert (flag_lt == (opd_a < opd_b));                    // R4
      AST_GE_INVERSE: assert (flag_ge != flag_lt);                         // R5
      AST_EQ_IMPLIES_GE: assert (!flag_eq || flag_ge);                     // R5
      AST_CARRY_SIGN: assert (sub_carry == (opd_b >= opd_a));              // R7
    end
  end
endmodule

bind cmp_flag_unit cmp_flag_unit_chk #(.WIDTH(WIDTH)) u_flag_chk (
  .opd_a     (opd_a),
  .opd_b     (opd_b),
  .flag_zero (flag_zero),
  .flag_ones (flag_ones),
  .flag_eq   (flag_eq),
  .flag_lt   (flag_lt),
  .flag_ge   (flag_ge),
  .sub_carry (sub_carry)
);

// File: tb/test_cmp_flag_unit.sv
`timescale 1ns/1ps
module test_cmp_flag_unit;
  localparam int unsigned NW = 4;
  localparam int unsigned WW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  logic [NW-1:0] na, nb;
  logic [WW-1:0] wa, wb;
  logic n_zero, n_ones, n_eq, n_lt, n_ge;
  logic w_zero, w_ones, w_eq, w_lt, w_ge;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  cmp_flag_unit #(.WIDTH(NW)) i_cmp_flag_unit (
    .opd_a(na), .opd_b(nb),
    .flag_zero(n_zero), .flag_ones(n_ones), .flag_eq(n_eq),
    .flag_lt(n_lt), .flag_ge(n_ge)
  );

  cmp_flag_unit #(.WIDTH(WW)) i_cmp_flag_unit_wide (
    .opd_a(wa), .opd_b(wb),
    .flag_zero(w_zero), .flag_ones(w_ones), .flag_eq(w_eq),
    .flag_lt(w_lt), .flag_ge(w_ge)
  );

  task automatic check(input logic got, input logic exp, input string req,
                       input longint av, input longint bv);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s a=%0h b=%0h actual=%b expected=%b", req, av, bv, got, exp);
    end
  endtask

  // Behavioural reference on integers, compared against all five flags.
  task automatic cmp_narrow(input int a, input int b);
    int maxv;
    maxv = (1 << NW) - 1;
    check(n_ones, a == maxv, "R1 ones(N=4)", a, b);
    check(n_zero, a == 0,    "R2 zero(N=4)", a, b);
    check(n_eq,   a == b,    "R3 eq(N=4)",   a, b);
    check(n_lt,   a < b,     "R4 lt(N=4)",   a, b);
    check(n_ge,   a >= b,    "R5 ge(N=4)",   a, b);
  endtask

  task automatic cmp_wide(input longint a, input longint b);
    longint maxv;
    maxv = (longint'(1) << WW) - 1;
    check(w_ones, a == maxv, "R1 ones(N=16)", a, b);
    check(w_zero, a == 0,    "R2 zero(N=16)", a, b);
    check(w_eq,   a == b,    "R3 eq(N=16)",   a, b);
    check(w_lt,   a < b,     "R4 lt(N=16)",   a, b);
    check(w_ge,   a >= b,    "R5 ge(N=16)",   a, b);
  endtask

  // Drive on the falling edge, compare at the following rising edge.
  task automatic apply_wide(input longint a, input longint b);
    @(negedge clk);
    wa = a[WW-1:0];
    wb = b[WW-1:0];
    @(posedge clk);
    #0.5;
    cmp_wide(a, b);
  endtask

  initial begin
    na = '0; nb = '0; wa = '0; wb = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #0.5;
    // Quiet state: both operands zero.
    check(n_zero, 1'b1, "R2 idle zero", 0, 0);
    check(n_eq,   1'b1, "R3 idle eq",   0, 0);
    check(w_ge,   1'b1, "R5 idle ge",   0, 0);

    // Exhaustive at width 4 (R1..R5, R7 via lt/ge).
    for (int a = 0; a < (1 << NW); a++) begin
      for (int b = 0; b < (1 << NW); b++) begin
        @(negedge clk);
        na = a[NW-1:0];
        nb = b[NW-1:0];
        @(posedge clk);
        #0.5;
        cmp_narrow(a, b);
      end
    end

    // Directed extremes at width 16.
    apply_wide(0, 16'hFFFF);
    apply_wide(16'hFFFF, 0);
    apply_wide(16'hFFFF, 16'hFFFF);
    apply_wide(0, 0);
    apply_wide(1, 0);
    apply_wide(0, 1);
    // R6: unsigned ordering across the top bit.
    apply_wide(16'h8000, 16'h7FFF);
    check(w_lt, 1'b0, "R6 0x8000 vs 0x7FFF lt", 16'h8000, 16'h7FFF);
    apply_wide(16'h7FFF, 16'h8000);
    check(w_lt, 1'b1, "R6 0x7FFF vs 0x8000 lt", 16'h7FFF, 16'h8000);

    // Random pairs, a quarter forced equal or one apart (R7 boundary).
    for (int i = 0; i < 3000; i++) begin
      longint ra, rb;
      ra = longint'($urandom_range(0, 16'hFFFF));
      rb = longint'($urandom_range(0, 16'hFFFF));
      if ((i % 8) == 0) rb = ra;
      else if ((i % 8) == 1) rb = (ra + 1) & 16'hFFFF;
      apply_wide(ra, rb);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule